// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block is a byte-wide parallel printer port that a host drives through three registers: an outgoing data byte, a printer status byte and a control byte. The printer is emulated inside the block. When the host raises the strobe line through a control write while select is asserted and init is released, the block marks the printer busy and emits the stored data byte on a byte-stream output as a one-cycle valid pulse. If interrupts are enabled, it also raises an interrupt request.

The host then polls the status register. The acknowledge and busy bits move forward one step on each status read, and the acknowledge step clears the interrupt. The host bus is synchronous. A write takes effect at the clock edge where `wr_en` is high. A read returns the register's value from before that edge on `rdata` one cycle later, and any side effect of the read is applied at the same edge. When `wr_en` and `rd_en` are both high, the write is performed and the read is dropped.

Top module: `ppc_port`

## Requirements
- R1: After reset, status reads 0xD9, control reads 0x0C, `irq` is 0 and `byte_valid` is 0.
- R2: Register offsets are data at 0, status at 1 and control at 2. Offsets 3 to 7 read as 0xFF and ignore writes. A write to the status offset leaves status unchanged.
- R3: A data read returns the byte sampled from `pin_data_in` when control bit 5 (direction) is 1. When that bit is 0, it returns the last byte written to the data offset.
- R4: Consider a control write with bit 2 (init) = 1, bit 3 (select) = 1 and bit 0 (strobe) = 1. It clears status bit 7 (not-busy). If the previously stored strobe bit was 0, the stored data byte appears on `byte_out` with `byte_valid` high for exactly one cycle. If the stored strobe was already 1, no pulse occurs.
- R5: On a control write as in R4, if the previously stored control bit 4 (interrupt enable) is 1, an interrupt becomes pending and `irq` goes to 1 in the cycle after the write.
- R6: A control write with bit 2 (init) = 0 sets status to 0xD8 (not-busy, ack, online and not-error set; timeout clear).
- R7: Consider a status read while status bit 7 is 0 and stored control bit 0 is 0. If status bit 6 (ack) is 1, it is cleared. Otherwise, bits 6 and 7 are set and the pending interrupt is cleared. The read returns the value from before the update.
- R8: A status read while status bit 7 is 1 or stored strobe is 1 leaves status and `irq` unchanged.
- R9: A control read returns the last byte written to the control offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` and held until the next read |
| pin_data_in | input | 8 | Input data lines, sampled every cycle |
| byte_out | output | 8 | Byte sent to the printer stream |
| byte_valid | output | 1 | One-cycle pulse qualifying `byte_out` |
| irq | output | 1 | Interrupt request, follows the pending flag |

## Verification
The hardest case to reach is the interrupt acknowledge path. It needs several conditions at once: the interrupt was enabled in the stored control value before the strobe write, busy is clear, the strobe has been lowered again, and two status reads have been made so that acknowledge first clears and then re-asserts. The stimulus programs control with interrupt enable and strobe low, raises strobe, and lowers it again. It then reads status twice and checks `irq` after each read. On the first read `irq` must stay high. On the second it must drop.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] OFS_DATA = 3'd0;
    localparam logic [AW-1:0] OFS_STAT = 3'd1;
    localparam logic [AW-1:0] OFS_CTRL = 3'd2;

    // status bit positions
    localparam int ST_NBUSY  = 7;
    localparam int ST_ACK    = 6;
    // control bit positions
    localparam int CT_DIR    = 5;
    localparam int CT_IEN    = 4;
    localparam int CT_SEL    = 3;
    localparam int CT_INIT   = 2;
    localparam int CT_STB    = 0;

    localparam logic [DW-1:0] STATUS_RST  = 8'hD9;
    localparam logic [DW-1:0] STATUS_INIT = 8'hD8;
    localparam logic [DW-1:0] CTRL_RST    = 8'h0C;
    localparam logic [DW-1:0] UNUSED_RD   = {DW{1'b1}};

    typedef struct packed {
        logic [DW-1:0] dataw;
        logic [DW-1:0] datar;
        logic [DW-1:0] status;
        logic [DW-1:0] control;
        logic          irq_pend;
        logic [DW-1:0] out_byte;
        logic          out_valid;
        logic [DW-1:0] rdata;
    } ppc_state_t;
endpackage

// File: rtl/ppc_ctrl_wr.sv
module ppc_ctrl_wr
    import ppc_pkg::*;
(
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ctrl_q,
    input  logic [DW-1:0] status_q,
    output logic [DW-1:0] status_nxt,
    output logic          emit,
    output logic          irq_set
);
    always_comb begin
        status_nxt = status_q;
        emit       = 1'b0;
        irq_set    = 1'b0;
        if (!wdata[CT_INIT]) begin
            status_nxt = STATUS_INIT;
        end else if (wdata[CT_SEL] && wdata[CT_STB]) begin
            status_nxt[ST_NBUSY] = 1'b0;
            emit    = !ctrl_q[CT_STB];
            irq_set = ctrl_q[CT_IEN];
        end
    end
endmodule

// File: rtl/ppc_stat_rd.sv
module ppc_stat_rd
    import ppc_pkg::*;
(
    input  logic [DW-1:0] status_q,
    input  logic [DW-1:0] ctrl_q,
    input  logic          irq_q,
    output logic [DW-1:0] status_nxt,
    output logic          irq_nxt
);
    always_comb begin
        status_nxt = status_q;
        irq_nxt    = irq_q;
        if (!status_q[ST_NBUSY] && !ctrl_q[CT_STB]) begin
            if (status_q[ST_ACK]) begin
                status_nxt[ST_ACK] = 1'b0;
            end else begin
                status_nxt[ST_ACK]   = 1'b1;
                status_nxt[ST_NBUSY] = 1'b1;
                irq_nxt              = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ppc_rd_mux.sv
module ppc_rd_mux
    import ppc_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dataw_q,
    input  logic [DW-1:0] datar_q,
    input  logic [DW-1:0] status_q,
    input  logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] rd_val
);
    always_comb begin
        unique case (addr)
            OFS_DATA: rd_val = ctrl_q[CT_DIR] ? datar_q : dataw_q;
            OFS_STAT: rd_val = status_q;
            OFS_CTRL: rd_val = ctrl_q;
            default:  rd_val = UNUSED_RD;
        endcase
    end
endmodule

// File: rtl/ppc_port.sv
module ppc_port
    import ppc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pin_data_in,
    output logic [DW-1:0] byte_out,
    output logic          byte_valid,
    output logic          irq
);
    ppc_state_t st_q, st_d;

    logic [DW-1:0] cw_status, sr_status, rd_val;
    logic          cw_emit, cw_irq_set, sr_irq;

    ppc_ctrl_wr u_cw (
        .wdata      (wdata),
        .ctrl_q     (st_q.control),
        .status_q   (st_q.status),
        .status_nxt (cw_status),
        .emit       (cw_emit),
        .irq_set    (cw_irq_set)
    );

    ppc_stat_rd u_sr (
        .status_q   (st_q.status),
        .ctrl_q     (st_q.control),
        .irq_q      (st_q.irq_pend),
        .status_nxt (sr_status),
        .irq_nxt    (sr_irq)
    );

    ppc_rd_mux u_mux (
        .addr     (addr),
        .dataw_q  (st_q.dataw),
        .datar_q  (st_q.datar),
        .status_q (st_q.status),
        .ctrl_q   (st_q.control),
        .rd_val   (rd_val)
    );

    always_comb begin
        st_d           = st_q;
        st_d.datar     = pin_data_in;
        st_d.out_valid = 1'b0;
        if (wr_en) begin
            case (addr)
                OFS_DATA: st_d.dataw = wdata;
                OFS_CTRL: begin
                    st_d.status  = cw_status;
                    st_d.control = wdata;
                    if (cw_emit) begin
                        st_d.out_byte  = st_q.dataw;
                        st_d.out_valid = 1'b1;
                    end
                    if (cw_irq_set) st_d.irq_pend = 1'b1;
                end
                default: ;
            endcase
        end else if (rd_en) begin
            st_d.rdata = rd_val;
            if (addr == OFS_STAT) begin
                st_d.status   = sr_status;
                st_d.irq_pend = sr_irq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dataw     <= '0;
            st_q.datar     <= '0;
            st_q.status    <= STATUS_RST;
            st_q.control   <= CTRL_RST;
            st_q.irq_pend  <= 1'b0;
            st_q.out_byte  <= '0;
            st_q.out_valid <= 1'b0;
            st_q.rdata     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata      = st_q.rdata;
    assign byte_out   = st_q.out_byte;
    assign byte_valid = st_q.out_valid;
    assign irq        = st_q.irq_pend;
endmodule

// File: rtl/ppc_port_chk.sv
module ppc_port_chk
    import ppc_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] wdata,
    input logic          byte_valid,
    input logic          irq
);
    // R4: a byte pulse lasts a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R4: a pulse only follows a control write with init, select and strobe set
    a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(wr_en && addr == OFS_CTRL && wdata[CT_STB]
                             && wdata[CT_SEL] && wdata[CT_INIT]));

    // R5: irq rises only after a strobe control write
    a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_en && addr == OFS_CTRL && wdata[CT_STB]));

    // R7: irq falls only after a status read
    a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_en && !wr_en && addr == OFS_STAT));

    // R2: unused offsets never cause activity on the outputs
    a_r2_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > OFS_CTRL) |=> (!byte_valid && $stable(irq)));
endmodule

bind ppc_port ppc_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .byte_valid (byte_valid),
    .irq        (irq)
);

// File: tb/tb_ppc_port.sv
`timescale 1ns/1ps
module tb_ppc_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, pin_data_in = '0;
    logic [7:0] rdata, byte_out;
    logic       byte_valid, irq;

    int total = 0, bad = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    ppc_port dut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic t_reset;
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 valid", {7'd0, byte_valid}, 8'h00);
        rd(3'd1, rv); check("R1 status", rv, 8'hD9);
        rd(3'd2, rv); check("R1 control", rv, 8'h0C);
    endtask

    task automatic t_unused;
        wr(3'd5, 8'h00);
        rd(3'd5, rv); check("R2 unused rd", rv, 8'hFF);
        rd(3'd7, rv); check("R2 unused rd7", rv, 8'hFF);
        wr(3'd1, 8'h00);
        rd(3'd1, rv); check("R2 status wr ignored", rv, 8'hD9);
        rd(3'd2, rv); check("R2 ctrl after unused wr", rv, 8'h0C);
    endtask

    task automatic t_data_dir;
        pin_data_in = 8'h3C;
        wr(3'd0, 8'hA5);
        rd(3'd0, rv); check("R3 data out", rv, 8'hA5);
        wr(3'd2, 8'h2C);
        rd(3'd0, rv); check("R3 data in", rv, 8'h3C);
        rd(3'd2, rv); check("R9 ctrl readback", rv, 8'h2C);
    endtask

    task automatic t_strobe;
        wr(3'd2, 8'h0C);
        wr(3'd0, 8'h41);
        @(negedge clk); addr = 3'd2; wdata = 8'h0D; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check("R4 valid", {7'd0, byte_valid}, 8'h01);
        check("R4 byte", byte_out, 8'h41);
        check("R5 no irq when disabled", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R4 one cycle", {7'd0, byte_valid}, 8'h00);
        rd(3'd1, rv); check("R4 busy clear", rv, 8'h59);
        // strobe still high: a repeat write must not emit
        @(negedge clk); addr = 3'd2; wdata = 8'h0D; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check("R4 no repeat pulse", {7'd0, byte_valid}, 8'h00);
        rd(3'd1, rv); check("R8 strobe high", rv, 8'h59);
        rd(3'd1, rv); check("R8 unchanged", rv, 8'h59);
        wr(3'd2, 8'h0C);
        rd(3'd1, rv); check("R7 pre-ack", rv, 8'h59);
        rd(3'd1, rv); check("R7 ack cleared", rv, 8'h19);
        rd(3'd1, rv); check("R7 ack busy set", rv, 8'hD9);
        rd(3'd1, rv); check("R8 busy set", rv, 8'hD9);
    endtask

    task automatic t_irq;
        wr(3'd2, 8'h1C);
        wr(3'd0, 8'h77);
        @(negedge clk); addr = 3'd2; wdata = 8'h1D; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check("R5 irq set", {7'd0, irq}, 8'h01);
        check("R4 byte 2", byte_out, 8'h77);
        wr(3'd2, 8'h1C);
        check("R5 irq held", {7'd0, irq}, 8'h01);
        rd(3'd1, rv); check("R7 read1", rv, 8'h59);
        check("R7 irq after ack clear", {7'd0, irq}, 8'h01);
        rd(3'd1, rv); check("R7 read2", rv, 8'h19);
        check("R7 irq cleared", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_init;
        wr(3'd2, 8'h08);
        rd(3'd1, rv); check("R6 init status", rv, 8'hD8);
        rd(3'd2, rv); check("R9 ctrl 08", rv, 8'h08);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset;
                t_unused;
                t_data_dir;
                t_strobe;
                t_irq;
                t_init;
            end
            begin
                repeat (5000) @(negedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule